// File: doc/BRIEF.md
# MMU Exception Entry Controller

This block sits after a single address-translation lookup and decides whether the lookup raises a processor exception. It takes the outcome of that lookup (whether an entry matched, that entry's valid and dirty bits and its way number), the direction of the access, and a flag that marks accesses in the tail of a hardware repeat loop. From these it picks one of three fault kinds: an invalid-entry fault, a first-write fault on a clean page, or a repeat-loop fault. Each kind has its own event code and its own rules for saving registers.

When a fault is taken, the block captures the faulting address and the page-entry context, and it saves the program counter and status word. It then drives the status word with the three mode bits (MD, RB and BL) forced high, and pulses a one-cycle redirect to the handler at the vector base plus 0x100. If the status word already shows exceptions blocked, nothing is captured and a separate error pulse is raised in place of the redirect.

Top module: `mmu_fault_entry`

## Requirements
- R1: A qualified lookup whose entry matched but whose valid bit is 0 is an invalid-entry fault. Its code is 0x040 for a read (`acc_write`=0) and 0x060 for a write. The dirty bit plays no part in this case.
- R2: A write that matches a valid entry with dirty bit 0 is a first-write fault with code 0x080. A read that matches a valid, clean entry raises no fault.
- R3: When `rpt_tail` is 1, any of a miss (`lkp_match`=0), an invalid entry or a first write yields code 0x070, and this code takes priority over R1 and R2. On this fault `saved_sr` is captured but `saved_pc` keeps its previous value. With `rpt_tail`=0, a miss raises no fault.
- R4: On a taken fault, `fault_addr` receives the whole logical address. `pte_hi` receives the address bits 31 to 10 in bits 31 to 10, zeros in bits 9 to 8 and the current ASID in bits 7 to 0. `way_sel` receives the matching way.
- R5: On an invalid-entry or first-write fault, `saved_pc` and `saved_sr` receive `pc_in` and `sr_in`.
- R6: The outputs of a taken fault appear on the clock edge that samples the strobe. `redirect` is high for exactly that cycle, with `redirect_pc` = `vbr_in` + 0x100. `sr_wdata` equals `sr_in` with bits 30 (MD), 29 (RB) and 28 (BL) set and every other bit unchanged.
- R7: If `sr_in` bit 28 is 1 when a fault is detected, no register changes, `redirect` stays low and `dbl_err` pulses for one cycle.
- R8: A cycle with `lkp_stb` low, or a qualified lookup with no fault, changes no register and produces no pulse.
- R9: An active-low synchronous reset clears `expevt`, `fault_addr` and `way_sel`, as well as the two pulse outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lkp_stb | input | 1 | Lookup result is valid this cycle |
| lkp_match | input | 1 | An entry matched the address |
| lkp_vbit | input | 1 | Valid bit of the matched entry |
| lkp_dbit | input | 1 | Dirty bit of the matched entry |
| lkp_way | input | WAY_W | Way of the matched entry |
| acc_write | input | 1 | 1 for a store, 0 for a load |
| rpt_tail | input | 1 | Access lies in the tail of a repeat loop |
| va_in | input | 32 | Faulting logical address |
| asid_in | input | ASID_W | Current address-space identifier |
| pc_in | input | 32 | PC of the accessing instruction |
| sr_in | input | 32 | Current status word |
| vbr_in | input | 32 | Vector base |
| redirect | output | 1 | One-cycle handler redirect pulse |
| redirect_pc | output | 32 | Handler address |
| sr_wdata | output | 32 | New status word, valid with redirect |
| dbl_err | output | 1 | Fault while exceptions blocked |
| expevt | output | 12 | Exception event code |
| fault_addr | output | 32 | Captured logical address |
| pte_hi | output | 32 | Page number and ASID context |
| way_sel | output | WAY_W | Captured way |
| saved_pc | output | 32 | Saved PC |
| saved_sr | output | 32 | Saved status word |

## Verification
The hardest situations to reach are those where two conditions overlap. One is a repeat-loop tail combined with a miss, which needs `rpt_tail` high and `lkp_match` low together. The other is any fault arriving while BL is already set, which must leave the saved PC untouched even though every other capture looks plausible. Directed steps build each overlap explicitly, and each one is preceded by a fault that loads known, distinct values into the saved registers, so that a wrong update can be seen. Random steps then hit the overlaps often, because the repeat and BL flags are drawn with raised probability.

// File: rtl/mmu_fault_entry.sv
module mmu_fault_entry #(
  parameter int WAY_W   = 2,
  parameter int ASID_W  = 8,
  parameter int VPN_LSB = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lkp_stb,
  input  logic              lkp_match,
  input  logic              lkp_vbit,
  input  logic              lkp_dbit,
  input  logic [WAY_W-1:0]  lkp_way,
  input  logic              acc_write,
  input  logic              rpt_tail,
  input  logic [31:0]       va_in,
  input  logic [ASID_W-1:0] asid_in,
  input  logic [31:0]       pc_in,
  input  logic [31:0]       sr_in,
  input  logic [31:0]       vbr_in,
  output logic              redirect,
  output logic [31:0]       redirect_pc,
  output logic [31:0]       sr_wdata,
  output logic              dbl_err,
  output logic [11:0]       expevt,
  output logic [31:0]       fault_addr,
  output logic [31:0]       pte_hi,
  output logic [WAY_W-1:0]  way_sel,
  output logic [31:0]       saved_pc,
  output logic [31:0]       saved_sr
);
  localparam int          BL_POS    = 28;
  localparam logic [31:0] MODE_BITS = 32'h7000_0000;
  localparam logic [31:0] HNDL_OFS  = 32'h0000_0100;
  localparam int          GAP_W     = VPN_LSB - ASID_W;

  logic inv_f, wr1_f, rpt_f, fault, take, blocked;
  logic [11:0] code;

  assign inv_f   = lkp_match & ~lkp_vbit;
  assign wr1_f   = lkp_match & lkp_vbit & ~lkp_dbit & acc_write;
  assign rpt_f   = rpt_tail & (~lkp_match | inv_f | wr1_f);
  assign fault   = rpt_f | inv_f | wr1_f;
  assign take    = lkp_stb & fault & ~sr_in[BL_POS];
  assign blocked = lkp_stb & fault &  sr_in[BL_POS];

  always_comb begin
    if (rpt_f)      code = 12'h070;
    else if (inv_f) code = acc_write ? 12'h060 : 12'h040;
    else            code = 12'h080;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect    <= 1'b0;
      dbl_err     <= 1'b0;
      redirect_pc <= '0;
      sr_wdata    <= '0;
      expevt      <= '0;
      fault_addr  <= '0;
      pte_hi      <= '0;
      way_sel     <= '0;
      saved_pc    <= '0;
      saved_sr    <= '0;
    end else begin
      redirect <= take;
      dbl_err  <= blocked;
      if (take) begin
        redirect_pc <= vbr_in + HNDL_OFS;
        sr_wdata    <= sr_in | MODE_BITS;
        expevt      <= code;
        fault_addr  <= va_in;
        pte_hi      <= {va_in[31:VPN_LSB], {GAP_W{1'b0}}, asid_in};
        way_sel     <= lkp_way;
        saved_sr    <= sr_in;
        if (!rpt_f) saved_pc <= pc_in;
      end
    end
  end

  p_code_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (expevt == 12'h040 || expevt == 12'h060 ||
                  expevt == 12'h070 || expevt == 12'h080));

  p_rpt_keeps_pc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && expevt == 12'h070) |-> $stable(saved_pc));

  p_vector_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && redirect |-> redirect_pc == $past(vbr_in) + HNDL_OFS);

  p_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_stb && sr_in[BL_POS] |=> !redirect && $stable(saved_pc) && $stable(expevt));

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_stb |=> !redirect && !dbl_err && $stable(expevt) && $stable(fault_addr));

  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(redirect && dbl_err));
endmodule

// File: tb/tb_mmu_fault_entry.sv
`timescale 1ns/1ps
module tb_mmu_fault_entry;
  logic clk = 0, rst_n = 0;
  logic stb = 0, match = 0, vb = 0, db = 0, wr = 0, rpt = 0;
  logic [1:0] way = 0;
  logic [31:0] va = 0, pc = 0, sr = 0, vbr = 0;
  logic [7:0] asid = 0;
  logic redirect, dbl_err;
  logic [31:0] redirect_pc, sr_wdata, fault_addr, pte_hi, saved_pc, saved_sr;
  logic [11:0] expevt;
  logic [1:0] way_sel;

  int checks = 0, fails = 0;
  logic [11:0] m_ev = 0; logic [31:0] m_tea = 0, m_pteh = 0, m_spc = 0, m_ssr = 0;
  logic [1:0] m_way = 0; logic m_redir = 0, m_err = 0;
  logic [31:0] m_rpc = 0, m_srw = 0;

  mmu_fault_entry dut (
    .clk(clk), .rst_n(rst_n), .lkp_stb(stb), .lkp_match(match), .lkp_vbit(vb),
    .lkp_dbit(db), .lkp_way(way), .acc_write(wr), .rpt_tail(rpt), .va_in(va),
    .asid_in(asid), .pc_in(pc), .sr_in(sr), .vbr_in(vbr), .redirect(redirect),
    .redirect_pc(redirect_pc), .sr_wdata(sr_wdata), .dbl_err(dbl_err),
    .expevt(expevt), .fault_addr(fault_addr), .pte_hi(pte_hi), .way_sel(way_sel),
    .saved_pc(saved_pc), .saved_sr(saved_sr));

  always #2.5 clk = ~clk;

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  function automatic logic [11:0] classify(logic m, logic v, logic d, logic w, logic r);
    logic inv = m & ~v;
    logic w1 = m & v & ~d & w;
    if (r && (!m || inv || w1)) return 12'h070;
    if (inv) return w ? 12'h060 : 12'h040;
    if (w1) return 12'h080;
    return 12'h000;
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    logic [11:0] c = stb ? classify(match, vb, db, wr, rpt) : 12'h000;
    m_redir = 0; m_err = 0;
    if (c != 0 && sr[28]) m_err = 1;
    else if (c != 0) begin
      m_redir = 1; m_ev = c; m_tea = va;
      m_pteh = {va[31:10], 2'b00, asid}; m_way = way; m_ssr = sr;
      if (c != 12'h070) m_spc = pc;
      m_rpc = vbr + 32'h100; m_srw = sr | 32'h7000_0000;
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "redirect", redirect, m_redir);
    chk(tag, "dbl_err", dbl_err, m_err);
    chk(tag, "expevt", expevt, m_ev);
    chk(tag, "fault_addr R4", fault_addr, m_tea);
    chk(tag, "pte_hi R4", pte_hi, m_pteh);
    chk(tag, "way_sel R4", way_sel, m_way);
    chk(tag, "saved_pc", saved_pc, m_spc);
    chk(tag, "saved_sr", saved_sr, m_ssr);
    if (m_redir) begin
      chk(tag, "redirect_pc R6", redirect_pc, m_rpc);
      chk(tag, "sr_wdata R6", sr_wdata, m_srw);
    end
  endtask

  task automatic step(string tag, logic s, logic m, logic v, logic d, logic w,
                      logic r, logic bl);
    @(negedge clk);
    stb = s; match = m; vb = v; db = d; wr = w; rpt = r;
    way = 2'($urandom); va = $urandom; asid = 8'($urandom); pc = $urandom;
    vbr = $urandom & 32'hFFFF_FC00;
    sr = ($urandom & 32'h8FFF_FFFF) | (bl ? 32'h1000_0000 : 32'h0);
    model_step();
    @(posedge clk); #1;
    compare(tag);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1;
    chk("R9", "reset expevt", expevt, 0);
    chk("R9", "reset fault_addr", fault_addr, 0);
    chk("R9", "reset way_sel", way_sel, 0);
    chk("R9", "reset redirect", redirect, 0);
    chk("R9", "reset dbl_err", dbl_err, 0);
    @(negedge clk); rst_n = 1;

    step("R1 inv read",        1,1,0,1,0,0,0);
    step("R6 pulse drop",      0,1,0,0,0,0,0);
    step("R1 inv write d0",    1,1,0,0,1,0,0);
    step("R2 first write",     1,1,1,0,1,0,0);
    step("R2 clean read none", 1,1,1,0,0,0,0);
    step("R8 dirty write",     1,1,1,1,1,0,0);
    step("R8 miss no rpt",     1,0,0,0,1,0,0);
    step("R5 setup",           1,1,0,0,0,0,0);
    step("R3 rpt miss",        1,0,1,1,0,1,0);
    step("R3 rpt inv",         1,1,0,0,1,1,0);
    step("R3 rpt first wr",    1,1,1,0,1,1,0);
    step("R8 rpt hit ok",      1,1,1,1,1,1,0);
    step("R7 bl inv",          1,1,0,0,0,0,1);
    step("R7 bl rpt",          1,0,0,0,0,1,1);
    step("R8 stb low fault",   0,1,0,0,1,1,0);
    step("R6 back to back a",  1,1,0,1,1,0,0);
    step("R6 back to back b",  1,1,1,0,1,0,0);

    for (int i = 0; i < 600; i++) begin
      logic s = ($urandom % 10) != 0;
      logic r = ($urandom % 4) == 0;
      logic bl = ($urandom % 6) == 0;
      step("R1-rand R2 R3 R5 R6 R7 R8", s, 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), r, bl);
    end

    @(negedge clk); rst_n = 0; stb = 0;
    @(posedge clk); #1;
    chk("R9", "reset2 expevt", expevt, 0);
    chk("R9", "reset2 fault_addr", fault_addr, 0);
    chk("R9", "reset2 way_sel", way_sel, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule